// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block is the transmit side of a single DMA channel. A control block hands it two pointers and a one-cycle start strobe. One pointer is to the first data descriptor. The other is to the context descriptor that owns the list. The engine then walks the list on its own. For each data descriptor it reads the buffer through a word-wide memory port, one word at a time. It sends the bytes in address order on a valid/ready byte stream. The buffer runs from a start address up to an exclusive "after" address. When a buffer is used up, the engine writes the descriptor back to memory. It then either moves on to the next pointer, or it marks the context disabled and stops with its end-of-list flag raised.

The stream obeys the usual valid/ready rules. A byte moves on any rising edge where `tx_valid_o` and `tx_ready_i` are both high. While `tx_ready_i` is low, the offered byte and its last marker do not change. While a byte is waiting, the engine issues no read for the next buffer word, so back-pressure stops memory traffic at once. The memory port is a request/acknowledge pair. The request, the address, the write enable and the write data stay unchanged until the acknowledge arrives. Read data is taken in the same cycle as the acknowledge.

The committed buffer position is given to the control block on `cur_buf_o`. It advances at fixed chunk boundaries and at the end of each buffer. The address of the descriptor in use is given on `cur_desc_o`. Each completion that asks for an interrupt produces a one-cycle pulse on `irq_set_o`.

Top module: `dma_desc_tx`

## Requirements
- R1: A data descriptor is four 32-bit words: next pointer at +0, buffer start at +4, flags at +8 and the exclusive after address at +12. A start strobe while idle loads the descriptor and context pointers, clears `eol_o` and fetches the descriptor.
- R2: The bytes from buffer start up to after−1 go out in ascending address order. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the word at a with its low two bits cleared.
- R3: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` and `tx_last_o` hold their values. No buffer word read is requested while a byte is still offered.
- R4: If flags bit 3 is set, `tx_last_o` is high on the final byte of that buffer and on no other byte. If bit 3 is clear, it is never high for that buffer.
- R5: If flags bit 4 is set, the completion of that descriptor produces exactly one single-cycle pulse on `irq_set_o`.
- R6: If flags bit 0 is clear when a descriptor completes, `cur_desc_o` takes the next pointer and that descriptor is fetched. `cur_buf_o` then takes its buffer start.
- R7: If flags bit 0 is set, the word at context pointer +4 is read, and then written back with bit 15 set and all other bits kept. After that `eol_o` goes high and the engine goes idle with no further memory requests.
- R8: After each descriptor completes, its four words are written back to their own addresses, and `cur_buf_o` equals its after address.
- R9: Within a buffer, `cur_buf_o` moves to the position reached after every CHUNK_BYTES bytes accepted since that descriptor was loaded.
- R10: A descriptor whose after address equals its buffer start completes with no byte sent. Its interrupt and end-of-list flags still act.
- R11: A start strobe while a list is being walked has no effect on the bytes sent, the descriptors fetched or `cur_desc_o`.
- R12: While `mem_req_o` is high and `mem_ack_i` is low, the request stays high and `mem_addr_o` and `mem_we_o` stay unchanged.
- R13: After reset, `tx_valid_o`, `mem_req_o`, `irq_set_o` and `eol_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe that begins a list walk |
| desc_ptr_i | input | 32 | Address of the first data descriptor |
| ctx_ptr_i | input | 32 | Address of the enclosing context descriptor |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | High for a write access |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access done; read data valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream byte offered |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of a packet-ending buffer |
| tx_ready_i | input | 1 | Sink accepts the byte |
| irq_set_o | output | 1 | Pulse: completion interrupt requested |
| eol_o | output | 1 | End of list reached; engine idle |
| cur_desc_o | output | 32 | Address of the current data descriptor |
| cur_buf_o | output | 32 | Committed buffer position |

## Verification
Two updates to `cur_buf_o` can fall on the same accepted byte: the chunk commit and the end-of-buffer commit. The bench provokes this with a buffer whose length is an exact multiple of a small chunk size. It records every distinct value `cur_buf_o` takes, and expects the final value once, with no extra step. A second buffer, not a multiple of the chunk size, shows the two commits landing apart. Interrupt completion and list-end handling also share one completion. The bench judges that by the pulse count together with the rewritten context word.

// File: rtl/dmatx_pkg.sv
package dmatx_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int DESC_WDS = 4;

  // flag bit positions inside the descriptor flags word
  localparam int FLG_EOL  = 0;
  localparam int FLG_OEOP = 3;
  localparam int FLG_INTR = 4;
  localparam int CTX_DIS  = 15;

  // word index inside a data descriptor
  localparam int DW_NEXT  = 0;
  localparam int DW_BUF   = 1;
  localparam int DW_FLAGS = 2;
  localparam int DW_AFTER = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DFETCH,
    ST_CHECK,
    ST_WFETCH,
    ST_SEND,
    ST_DONE,
    ST_DSTORE,
    ST_CREAD,
    ST_CWRITE
  } seq_state_t;
endpackage

// File: rtl/dmatx_out_slot.sv
module dmatx_out_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          lin,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] dout,
  output logic          lout,
  output logic          can_push
);
  assign can_push = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
      lout  <= 1'b0;
    end else if (push) begin
      valid <= 1'b1;
      dout  <= din;
      lout  <= lin;
    end else if (ready) begin
      valid <= 1'b0;
      lout  <= 1'b0;
    end
  end
endmodule

// File: rtl/dmatx_chunk.sv
module dmatx_chunk #(
  parameter int CHUNK = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic wrap
);
  localparam int CW = (CHUNK > 1) ? $clog2(CHUNK) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(CHUNK - 1);

  logic [CW-1:0] cnt;

  assign wrap = step && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (step)     cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/dmatx_seq.sv
module dmatx_seq
  import dmatx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] desc_ptr,
  input  logic [WORD_W-1:0] ctx_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              can_push,
  input  logic              slot_empty,
  output logic              push,
  output logic [BYTE_W-1:0] push_byte,
  output logic              push_last,
  output logic              chunk_clr,
  input  logic              chunk_wrap,
  output logic              irq_set,
  output logic              eol,
  output logic [WORD_W-1:0] cur_desc,
  output logic [WORD_W-1:0] cur_buf,
  output logic              buf_fetch
);
  seq_state_t st;
  logic [1:0]        idx;
  logic [WORD_W-1:0] dw [DESC_WDS];
  logic [WORD_W-1:0] ptr;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] ctx_q;
  logic [WORD_W-1:0] ctx_flags;
  logic              at_end;
  logic [WORD_W-1:0] ptr_inc;

  assign ptr_inc = ptr + 1'b1;
  assign at_end  = (ptr_inc == dw[DW_AFTER]);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      ST_DFETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_desc + {{(WORD_W-4){1'b0}}, idx, 2'b00};
      end
      ST_WFETCH: begin
        mem_req  = slot_empty;
        mem_addr = {ptr[WORD_W-1:2], 2'b00};
      end
      ST_DSTORE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_desc + {{(WORD_W-4){1'b0}}, idx, 2'b00};
        mem_wdata = dw[idx];
      end
      ST_CREAD: begin
        mem_req  = 1'b1;
        mem_addr = ctx_q + 32'd4;
      end
      ST_CWRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ctx_q + 32'd4;
        mem_wdata = ctx_flags | (32'd1 << CTX_DIS);
      end
      default: ;
    endcase
  end

  assign buf_fetch = (st == ST_WFETCH) && mem_req;
  assign push      = (st == ST_SEND) && can_push;
  assign push_byte = word_q[{ptr[1:0], 3'b000} +: BYTE_W];
  assign push_last = at_end && dw[DW_FLAGS][FLG_OEOP];
  assign chunk_clr = (st == ST_DFETCH);
  assign irq_set   = (st == ST_DONE) && dw[DW_FLAGS][FLG_INTR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      ptr       <= '0;
      word_q    <= '0;
      ctx_q     <= '0;
      ctx_flags <= '0;
      cur_desc  <= '0;
      cur_buf   <= '0;
      eol       <= 1'b0;
      for (int i = 0; i < DESC_WDS; i++) dw[i] <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          cur_desc <= desc_ptr;
          ctx_q    <= ctx_ptr;
          eol      <= 1'b0;
          idx      <= '0;
          st       <= ST_DFETCH;
        end
        ST_DFETCH: if (mem_ack) begin
          dw[idx] <= mem_rdata;
          if (idx == 2'(DW_BUF)) begin
            ptr     <= mem_rdata;
            cur_buf <= mem_rdata;
          end
          if (idx == 2'(DESC_WDS - 1)) begin
            idx <= '0;
            st  <= ST_CHECK;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_CHECK: st <= (ptr == dw[DW_AFTER]) ? ST_DONE : ST_WFETCH;
        ST_WFETCH: if (mem_ack) begin
          word_q <= mem_rdata;
          st     <= ST_SEND;
        end
        ST_SEND: if (push) begin
          ptr <= ptr_inc;
          if (chunk_wrap) cur_buf <= ptr_inc;
          if (at_end)               st <= ST_DONE;
          else if (ptr[1:0] == 2'b11) st <= ST_WFETCH;
        end
        ST_DONE: begin
          cur_buf <= ptr;
          idx     <= '0;
          st      <= ST_DSTORE;
        end
        ST_DSTORE: if (mem_ack) begin
          if (idx == 2'(DESC_WDS - 1)) begin
            idx <= '0;
            if (dw[DW_FLAGS][FLG_EOL]) begin
              st <= ST_CREAD;
            end else begin
              cur_desc <= dw[DW_NEXT];
              st       <= ST_DFETCH;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_CREAD: if (mem_ack) begin
          ctx_flags <= mem_rdata;
          st        <= ST_CWRITE;
        end
        ST_CWRITE: if (mem_ack) begin
          eol <= 1'b1;
          st  <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_desc_tx.sv
module dma_desc_tx
  import dmatx_pkg::*;
#(
  parameter int CHUNK_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] desc_ptr_i,
  input  logic [31:0] ctx_ptr_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i,
  output logic        irq_set_o,
  output logic        eol_o,
  output logic [31:0] cur_desc_o,
  output logic [31:0] cur_buf_o
);
  logic              can_push;
  logic              push;
  logic [BYTE_W-1:0] push_byte;
  logic              push_last;
  logic              chunk_clr;
  logic              chunk_wrap;
  logic              buf_fetch;

  dmatx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .desc_ptr   (desc_ptr_i),
    .ctx_ptr    (ctx_ptr_i),
    .mem_req    (mem_req_o),
    .mem_we     (mem_we_o),
    .mem_addr   (mem_addr_o),
    .mem_wdata  (mem_wdata_o),
    .mem_ack    (mem_ack_i),
    .mem_rdata  (mem_rdata_i),
    .can_push   (can_push),
    .slot_empty (!tx_valid_o),
    .push       (push),
    .push_byte  (push_byte),
    .push_last  (push_last),
    .chunk_clr  (chunk_clr),
    .chunk_wrap (chunk_wrap),
    .irq_set    (irq_set_o),
    .eol        (eol_o),
    .cur_desc   (cur_desc_o),
    .cur_buf    (cur_buf_o),
    .buf_fetch  (buf_fetch)
  );

  dmatx_chunk #(.CHUNK(CHUNK_BYTES)) u_chunk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (chunk_clr),
    .step  (push),
    .wrap  (chunk_wrap)
  );

  dmatx_out_slot #(.DW(BYTE_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .din      (push_byte),
    .lin      (push_last),
    .ready    (tx_ready_i),
    .valid    (tx_valid_o),
    .dout     (tx_data_o),
    .lout     (tx_last_o),
    .can_push (can_push)
  );
endmodule

// File: rtl/dma_desc_tx_chk.sv
module dma_desc_tx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        irq_set,
  input logic        eol,
  input logic        buf_fetch
);
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R3

  AST_NO_FETCH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    buf_fetch |-> !tx_valid); // R3

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> !irq_set); // R5

  AST_EOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    eol |-> !mem_req); // R7

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12
endmodule

bind dma_desc_tx dma_desc_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req_o),
  .mem_we    (mem_we_o),
  .mem_ack   (mem_ack_i),
  .mem_addr  (mem_addr_o),
  .tx_valid  (tx_valid_o),
  .tx_ready  (tx_ready_i),
  .tx_data   (tx_data_o),
  .tx_last   (tx_last_o),
  .irq_set   (irq_set_o),
  .eol       (eol_o),
  .buf_fetch (buf_fetch)
);

// File: tb/dma_desc_tx_tb.sv
module dma_desc_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CHUNK      = 4;
  localparam logic [31:0] CTX   = 32'h3F0;
  localparam logic [31:0] CTXW0 = 32'h0000_00A1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] desc_ptr = '0;
  logic [31:0] ctx_ptr = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        tx_valid, tx_last, tx_ready, irq_set, eol;
  logic [7:0]  tx_data;
  logic [31:0] cur_desc, cur_buf;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic toggle_ready = 1'b0;

  logic [31:0] mem [0:255];
  logic [7:0]  rx_d [0:255];
  logic        rx_l [0:255];
  int          rx_n = 0;
  int          irq_n = 0;
  logic [31:0] wr_a [0:255];
  logic [31:0] wr_v [0:255];
  int          wr_n = 0;
  logic [31:0] cb_log [0:255];
  int          cb_n = 0;
  logic [31:0] cb_prev = '0;
  int          stall_err = 0, fetch_err = 0, hold_err = 0;
  logic        p_stall = 1'b0, p_req = 1'b0, p_l = 1'b0, p_we = 1'b0;
  logic [7:0]  p_d = '0;
  logic [31:0] p_a = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign tx_ready = !toggle_ready || (cyc % 3 == 0);

  dma_desc_tx #(.CHUNK_BYTES(CHUNK)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .desc_ptr_i(desc_ptr),
    .ctx_ptr_i(ctx_ptr), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready), .irq_set_o(irq_set),
    .eol_o(eol), .cur_desc_o(cur_desc), .cur_buf_o(cur_buf)
  );

  // memory model and monitors
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_we) begin
          mem[mem_addr[9:2]] <= mem_wdata;
          wr_a[wr_n] <= mem_addr;
          wr_v[wr_n] <= mem_wdata;
          wr_n <= wr_n + 1;
        end
      end
    end
    if (tx_valid && tx_ready) begin
      rx_d[rx_n] <= tx_data;
      rx_l[rx_n] <= tx_last;
      rx_n <= rx_n + 1;
    end
    if (irq_set) irq_n <= irq_n + 1;
    if (rst_n && cur_buf != cb_prev) begin
      cb_log[cb_n] <= cur_buf;
      cb_n <= cb_n + 1;
    end
    cb_prev <= cur_buf;
    if (p_stall && !(tx_valid && tx_data == p_d && tx_last == p_l)) stall_err <= stall_err + 1;
    p_stall <= rst_n && tx_valid && !tx_ready;
    p_d <= tx_data;
    p_l <= tx_last;
    if (rst_n && mem_req && !mem_we && mem_addr >= 32'h100 && mem_addr < CTX && tx_valid)
      fetch_err <= fetch_err + 1;
    if (p_req && (!mem_req || mem_addr != p_a || mem_we != p_we)) hold_err <= hold_err + 1;
    p_req <= rst_n && mem_req && !mem_ack;
    p_a <= mem_addr;
    p_we <= mem_we;
  end

  function automatic logic [7:0] pat(int a);
    return 8'(a ^ 'h5A ^ (a >> 8));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int w = 0; w < 256; w++) mem[w] = '0;
    for (int a = 32'h100; a < 32'h3F0; a++) mem[a >> 2][8*(a % 4) +: 8] = pat(a);
    mem[CTX[9:2] + 1] = CTXW0;
  endtask

  task automatic put_desc(input logic [31:0] d, input logic [31:0] nx, input logic [31:0] b,
                          input logic [31:0] f, input logic [31:0] af);
    mem[d[9:2]]     = nx;
    mem[d[9:2] + 1] = b;
    mem[d[9:2] + 2] = f;
    mem[d[9:2] + 3] = af;
  endtask

  task automatic kick(input logic [31:0] d);
    @(negedge clk);
    start = 1'b1; desc_ptr = d; ctx_ptr = CTX;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(eol && !tx_valid) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  // compare received bytes from index base against buffer [b, af)
  task automatic cmp_bytes(input int base, input logic [31:0] b, input logic [31:0] af,
                           input bit last_exp, input string tag);
    int bad = 0;
    for (int a = int'(b); a < int'(af); a++) begin
      int i = base + a - int'(b);
      if (rx_d[i] != pat(a)) bad++;
      if (rx_l[i] != (last_exp && a == int'(af) - 1)) bad++;
    end
    chk(bad == 0, tag, 32'(bad), 0);
  endtask

  function automatic int writes_in(input int wbase, input logic [31:0] lo, input logic [31:0] hi);
    int c = 0;
    for (int k = wbase; k < wr_n; k++) if (wr_a[k] >= lo && wr_a[k] <= hi) c++;
    return c;
  endfunction

  task automatic t_reset();
    chk(!tx_valid && !mem_req && !irq_set && !eol, "R13 reset outputs",
        {28'd0, tx_valid, mem_req, irq_set, eol}, 0);
  endtask

  task automatic t_single();
    int rb = rx_n, ib = irq_n, wb = wr_n, ok = 1;
    init_mem();
    put_desc(32'h000, 32'h040, 32'h102, 32'h1234_0019, 32'h109);
    toggle_ready = 1'b0;
    kick(32'h000);
    wait_end();
    chk(rx_n - rb == 7, "R2 byte count", 32'(rx_n - rb), 7);
    cmp_bytes(rb, 32'h102, 32'h109, 1'b1, "R2 R4 bytes and last marker");
    chk(irq_n - ib == 1, "R5 one interrupt pulse", 32'(irq_n - ib), 1);
    chk(eol, "R7 eol flag", 32'(eol), 1);
    chk(mem[CTX[9:2] + 1] == (CTXW0 | 32'h8000), "R7 context disable bit",
        mem[CTX[9:2] + 1], CTXW0 | 32'h8000);
    chk(writes_in(wb, 32'h000, 32'h00C) == 4, "R8 descriptor writeback count",
        32'(writes_in(wb, 32'h000, 32'h00C)), 4);
    for (int k = wb; k < wr_n; k++)
      if (wr_a[k] <= 32'h00C && wr_v[k] != mem[wr_a[k][9:2]]) ok = 0;
    chk(ok == 1 && mem[2] == 32'h1234_0019, "R1 R8 writeback values", mem[2], 32'h1234_0019);
    chk(cur_buf == 32'h109, "R8 saved buffer at after", cur_buf, 32'h109);
    chk(cur_desc == 32'h000, "R1 current descriptor", cur_desc, 0);
  endtask

  task automatic t_chain();
    int rb = rx_n, ib = irq_n, wb = wr_n;
    init_mem();
    put_desc(32'h010, 32'h020, 32'h130, 32'h08, 32'h135);
    put_desc(32'h020, 32'h030, 32'h150, 32'h10, 32'h150);
    put_desc(32'h030, 32'h000, 32'h161, 32'h11, 32'h16B);
    toggle_ready = 1'b1;
    kick(32'h010);
    wait_end();
    toggle_ready = 1'b0;
    chk(rx_n - rb == 15, "R6 R10 chain byte count", 32'(rx_n - rb), 15);
    cmp_bytes(rb, 32'h130, 32'h135, 1'b1, "R4 first buffer with last");
    cmp_bytes(rb + 5, 32'h161, 32'h16B, 1'b0, "R2 R4 third buffer no last");
    chk(irq_n - ib == 2, "R5 R10 interrupts in chain", 32'(irq_n - ib), 2);
    chk(cur_desc == 32'h030, "R6 followed next pointers", cur_desc, 32'h030);
    chk(writes_in(wb, 32'h010, 32'h03C) == 12, "R8 chain writebacks",
        32'(writes_in(wb, 32'h010, 32'h03C)), 12);
    chk(stall_err == 0, "R3 stall stability", 32'(stall_err), 0);
    chk(fetch_err == 0, "R3 no fetch while byte pending", 32'(fetch_err), 0);
  endtask

  task automatic t_zero();
    int rb = rx_n, ib = irq_n;
    init_mem();
    put_desc(32'h050, 32'h000, 32'h180, 32'h11, 32'h180);
    kick(32'h050);
    wait_end();
    chk(rx_n == rb, "R10 zero length sends nothing", 32'(rx_n - rb), 0);
    chk(irq_n - ib == 1, "R10 zero length interrupt", 32'(irq_n - ib), 1);
    chk(eol && mem[CTX[9:2] + 1] == (CTXW0 | 32'h8000), "R7 R10 zero length end of list",
        mem[CTX[9:2] + 1], CTXW0 | 32'h8000);
  endtask

  task automatic t_chunk();
    int cb;
    init_mem();
    put_desc(32'h060, 32'h000, 32'h200, 32'h01, 32'h20A);
    cb = cb_n;
    kick(32'h060);
    wait_end();
    chk(cb_n - cb == 4 && cb_log[cb] == 32'h200 && cb_log[cb+1] == 32'h204 &&
        cb_log[cb+2] == 32'h208 && cb_log[cb+3] == 32'h20A,
        "R9 chunk commits apart from end", 32'(cb_n - cb), 4);
    init_mem();
    put_desc(32'h070, 32'h000, 32'h220, 32'h01, 32'h228);
    cb = cb_n;
    kick(32'h070);
    wait_end();
    chk(cb_n - cb == 3 && cb_log[cb] == 32'h220 && cb_log[cb+1] == 32'h224 &&
        cb_log[cb+2] == 32'h228, "R9 chunk commit coinciding with end", 32'(cb_n - cb), 3);
  endtask

  task automatic t_restart();
    int rb = rx_n, wb = wr_n;
    init_mem();
    put_desc(32'h080, 32'h000, 32'h1C0, 32'h01, 32'h1E0);
    put_desc(32'h010, 32'h000, 32'h300, 32'h01, 32'h310);
    toggle_ready = 1'b1;
    kick(32'h080);
    repeat (6) @(negedge clk);
    start = 1'b1; desc_ptr = 32'h010;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    toggle_ready = 1'b0;
    chk(rx_n - rb == 32, "R11 byte count unchanged", 32'(rx_n - rb), 32);
    cmp_bytes(rb, 32'h1C0, 32'h1E0, 1'b0, "R11 bytes unchanged");
    chk(cur_desc == 32'h080, "R11 descriptor unchanged", cur_desc, 32'h080);
    chk(writes_in(wb, 32'h010, 32'h01C) == 0, "R11 other list untouched",
        32'(writes_in(wb, 32'h010, 32'h01C)), 0);
    chk(hold_err == 0, "R12 request held until ack", 32'(hold_err), 0);
  endtask

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_chain();
    t_zero();
    t_chunk();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule